// File: doc/BRIEF.md
# Interrupt Latch and Enable Controller

This block gathers interrupt requests from hardware sources numbered 2 to 28 into pending latches. It filters them through a per-source enable mask and a master enable flag. The lowest-numbered eligible source is presented to the processor core as a single request with a 5-bit index. Sources 2 and 3 form the non-maskable group, so neither the master flag nor the enable mask affects them.

When the core accepts the presented request, the pending bit of that source is dropped. The master enable value is saved on a small stack and the flag is then cleared, which keeps further maskable requests out until the handler returns. A return strobe pops the saved value back. Software sees the latch and enable state through a byte-wide register port. Writes to the latch bytes can only clear bits, never set them.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset every pending latch, every enable bit and the master enable flag read 0, and `req_valid` is 0.
- R2: A 1 on `irq_req[i]` for a cycle, with i in 2..28, sets pending bit i. Bits 0, 1 and 29..31 of `irq_req` are ignored. Pending bit i is visible at bit i%8 of the latch byte for lane i/8.
- R3: A write to a latch byte clears each bit whose write-data bit is 0 and leaves each bit whose write-data bit is 1 unchanged. A write never sets a pending bit.
- R4: When a hardware request and a clear of the same pending bit fall in the same cycle, the bit ends up set. The clear may come from a register write or from an accept.
- R5: Sources 4..28 are eligible only while the master enable is 1 and their own enable bit is 1.
- R6: Sources 2 and 3 are eligible whenever their pending bit is set, whatever the enable register holds.
- R7: `req_valid` is 1 exactly when some pending source is eligible, and `req_idx` is then the lowest eligible index. Both outputs reflect the state after the most recent clock edge.
- R8: `irq_ack` while `req_valid` is 1 clears the pending bit at `req_idx`, pushes the master enable onto the save stack and clears the master enable. `irq_ack` while `req_valid` is 0 has no effect.
- R9: `irq_reti` pops the newest saved value into the master enable. An empty stack yields 0. The stack holds 8 values, and a push onto a full stack discards the oldest one.
- R10: The enable lanes 0..3 sit at addresses 0x3A, 0x3B, 0x2C and 0x2D, and the latch lanes 0..3 at 0x3C, 0x3D, 0x2E and 0x2F. The master enable is bit 0 of lane 0 of the enable register. Enable bits 1..3 and 29..31 and latch bits 0, 1 and 29..31 read 0. Other addresses read 0 and ignore writes. `reg_rdata` shows, one cycle after the address is presented, the state before that edge.
- R11: The master enable is updated with the priority accept, then return, then a register write to 0x3A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 32 | Hardware request pulses, bit per source |
| irq_ack | input | 1 | Core accepts the presented request |
| irq_reti | input | 1 | Core returns from an interrupt handler |
| reg_addr | input | 8 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| req_valid | output | 1 | An eligible request is pending |
| req_idx | output | 5 | Index of the selected source |

## Verification
Single requests are raised first, one source at a time, to show that each source lands in the right lane and bit. Then several sources are made pending at once with different enable patterns, which separates the lowest-index priority and the master-flag gating from the non-maskable bypass. Accept and return sequences run deeper than the stack, with the master flag changed between steps, to expose errors in ordering, overflow and the empty pop. Same-cycle collisions of set and clear, and of accept, return and write, test the precedence rules. A long pseudo-random sweep ends the run.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

  typedef struct packed {
    logic       hit_en;
    logic       hit_lat;
    logic [1:0] lane;
  } reg_sel_t;

  function automatic reg_sel_t decode_addr(input logic [7:0] addr);
    reg_sel_t s;
    s = '0;
    case (addr)
      8'h3A: begin s.hit_en  = 1'b1; s.lane = 2'd0; end
      8'h3B: begin s.hit_en  = 1'b1; s.lane = 2'd1; end
      8'h2C: begin s.hit_en  = 1'b1; s.lane = 2'd2; end
      8'h2D: begin s.hit_en  = 1'b1; s.lane = 2'd3; end
      8'h3C: begin s.hit_lat = 1'b1; s.lane = 2'd0; end
      8'h3D: begin s.hit_lat = 1'b1; s.lane = 2'd1; end
      8'h2E: begin s.hit_lat = 1'b1; s.lane = 2'd2; end
      8'h2F: begin s.hit_lat = 1'b1; s.lane = 2'd3; end
      default: s = '0;
    endcase
    return s;
  endfunction

  function automatic logic [31:0] range_mask(input int lo, input int hi);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) if (i >= lo && i <= hi) m[i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int VEC_W = 32,
  parameter logic [VEC_W-1:0] KEEP = '1,
  localparam int IDX_W = $clog2(VEC_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VEC_W-1:0] set_vec,
  input  logic             wr_en,
  input  logic [1:0]       wr_lane,
  input  logic [7:0]       wr_data,
  input  logic             ack_clr,
  input  logic [IDX_W-1:0] ack_idx,
  output logic [VEC_W-1:0] lat_q,
  output logic [VEC_W-1:0] lat_d
);

  always_comb begin
    lat_d = lat_q;
    if (wr_en) lat_d[int'(wr_lane)*8 +: 8] = lat_q[int'(wr_lane)*8 +: 8] & wr_data;
    if (ack_clr) lat_d[ack_idx] = 1'b0;
    lat_d = (lat_d | set_vec) & KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) lat_q <= '0;
    else     lat_q <= lat_d;
  end

endmodule

// File: rtl/irq_mstk.sv
module irq_mstk #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic pop,
  input  logic wr_en,
  input  logic wr_val,
  output logic imf_q,
  output logic imf_d
);

  logic [DEPTH-1:0] stk_q, stk_d;

  always_comb begin
    imf_d = imf_q;
    stk_d = stk_q;
    if (push) begin
      stk_d = {stk_q[DEPTH-2:0], imf_q};
      imf_d = 1'b0;
    end else if (pop) begin
      imf_d = stk_q[0];
      stk_d = {1'b0, stk_q[DEPTH-1:1]};
    end else if (wr_en) begin
      imf_d = wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      imf_q <= 1'b0;
      stk_q <= '0;
    end else begin
      imf_q <= imf_d;
      stk_q <= stk_d;
    end
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int VEC_W = 32,
  parameter logic [VEC_W-1:0] NMI_SET = '0,
  localparam int IDX_W = $clog2(VEC_W)
) (
  input  logic [VEC_W-1:0] lat,
  input  logic [VEC_W-1:0] en,
  input  logic             imf,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);

  logic [VEC_W-1:0] elig;

  always_comb begin
    elig  = lat & ((en & {VEC_W{imf}}) | NMI_SET);
    valid = |elig;
    idx   = '0;
    for (int i = VEC_W - 1; i >= 0; i--) begin
      if (elig[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
  parameter int VEC_W     = 32,
  parameter int SRC_LO    = 2,
  parameter int SRC_HI    = 28,
  parameter int NMI_HI    = 3,
  parameter int STK_DEPTH = 8,
  localparam int IDX_W    = $clog2(VEC_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VEC_W-1:0] irq_req,
  input  logic             irq_ack,
  input  logic             irq_reti,
  input  logic [7:0]       reg_addr,
  input  logic             reg_we,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             req_valid,
  output logic [IDX_W-1:0] req_idx
);
  import irq_latch_pkg::*;

  localparam logic [VEC_W-1:0] SRC_SET = VEC_W'(range_mask(SRC_LO, SRC_HI));
  localparam logic [VEC_W-1:0] NMI_SET = VEC_W'(range_mask(SRC_LO, NMI_HI));
  localparam logic [VEC_W-1:0] MSK_SET = VEC_W'(range_mask(NMI_HI + 1, SRC_HI));

  reg_sel_t         sel;
  logic             take;
  logic [VEC_W-1:0] lat_q, lat_d;
  logic [VEC_W-1:0] en_q, en_d;
  logic             imf_q, imf_d;
  logic             pick_v;
  logic [IDX_W-1:0] pick_i;
  logic [VEC_W-1:0] en_view, rd_vec;

  assign sel  = decode_addr(reg_addr);
  assign take = irq_ack & req_valid;

  irq_pend_bank #(.VEC_W(VEC_W), .KEEP(SRC_SET)) u_bank (
    .clk(clk), .rst(rst), .set_vec(irq_req),
    .wr_en(reg_we & sel.hit_lat), .wr_lane(sel.lane), .wr_data(reg_wdata),
    .ack_clr(take), .ack_idx(req_idx),
    .lat_q(lat_q), .lat_d(lat_d)
  );

  irq_mstk #(.DEPTH(STK_DEPTH)) u_stk (
    .clk(clk), .rst(rst), .push(take), .pop(irq_reti),
    .wr_en(reg_we & sel.hit_en & (sel.lane == 2'd0)), .wr_val(reg_wdata[0]),
    .imf_q(imf_q), .imf_d(imf_d)
  );

  always_comb begin
    en_d = en_q;
    if (reg_we && sel.hit_en) en_d[int'(sel.lane)*8 +: 8] = reg_wdata;
    en_d = en_d & MSK_SET;
  end

  irq_pick #(.VEC_W(VEC_W), .NMI_SET(NMI_SET)) u_pick (
    .lat(lat_d), .en(en_d), .imf(imf_d), .valid(pick_v), .idx(pick_i)
  );

  assign en_view = en_q | VEC_W'(imf_q);
  always_comb begin
    rd_vec = '0;
    if (sel.hit_en)  rd_vec = en_view;
    if (sel.hit_lat) rd_vec = lat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      req_valid <= 1'b0;
      req_idx   <= '0;
      reg_rdata <= '0;
    end else begin
      en_q      <= en_d;
      req_valid <= pick_v;
      req_idx   <= pick_i;
      reg_rdata <= rd_vec[int'(sel.lane)*8 +: 8];
    end
  end

endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] irq_req,
  input logic        irq_ack,
  input logic        reg_we,
  input logic [7:0]  reg_addr,
  input logic        req_valid,
  input logic [4:0]  req_idx,
  input logic [31:0] lat_q,
  input logic [31:0] en_q,
  input logic        imf_q
);
  import irq_latch_pkg::*;

  logic lat_wr;
  assign lat_wr = reg_we && decode_addr(reg_addr).hit_lat;

  // R8
  imf_clear_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && req_valid) |=> !imf_q);

  // R5
  maskable_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_idx >= 5'd4) |-> (imf_q && en_q[req_idx]));

  // R7
  idx_pending_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> lat_q[req_idx]);

  // R6
  nmi_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (lat_q[2] || lat_q[3]) |-> req_valid);

  // R3
  write_never_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (lat_wr && irq_req == 32'd0) |=> ((lat_q & ~$past(lat_q)) == 32'd0));

endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .irq_req(irq_req), .irq_ack(irq_ack),
  .reg_we(reg_we), .reg_addr(reg_addr), .req_valid(req_valid),
  .req_idx(req_idx), .lat_q(lat_q), .en_q(en_q), .imf_q(imf_q)
);

// File: tb/irq_latch_ctrl_tb.sv
module irq_latch_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_req = '0;
  logic        irq_ack = 1'b0;
  logic        irq_reti = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        req_valid;
  logic [4:0]  req_idx;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference state
  logic [31:0] m_lat = '0;
  logic [31:0] m_en = '0;
  logic        m_imf = 1'b0;
  bit          m_stk[$];
  logic        e_valid = 1'b0;
  logic [4:0]  e_idx = '0;
  logic [7:0]  e_rd = '0;

  always #5 clk = ~clk;

  irq_latch_ctrl u_dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_ack(irq_ack),
    .irq_reti(irq_reti), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_idx(req_idx)
  );

  function automatic int lane_of(input logic [7:0] a, output bit is_en, output bit is_lat);
    is_en = 0; is_lat = 0;
    case (a)
      8'h3A: begin is_en = 1; return 0; end
      8'h3B: begin is_en = 1; return 1; end
      8'h2C: begin is_en = 1; return 2; end
      8'h2D: begin is_en = 1; return 3; end
      8'h3C: begin is_lat = 1; return 0; end
      8'h3D: begin is_lat = 1; return 1; end
      8'h2E: begin is_lat = 1; return 2; end
      8'h2F: begin is_lat = 1; return 3; end
      default: return 0;
    endcase
  endfunction

  task automatic model_update();
    bit is_en, is_lat;
    int ln;
    bit accept;
    logic [31:0] v;
    ln = lane_of(reg_addr, is_en, is_lat);
    if (rst) begin
      m_lat = '0; m_en = '0; m_imf = 0; m_stk.delete();
      e_rd = '0; e_valid = 0; e_idx = '0;
      return;
    end
    v = '0;
    if (is_en) v = m_en | {31'd0, m_imf};
    if (is_lat) v = m_lat;
    e_rd = v[ln*8 +: 8];
    accept = irq_ack && e_valid;
    if (reg_we && is_lat) m_lat[ln*8 +: 8] = m_lat[ln*8 +: 8] & reg_wdata;
    if (accept) m_lat[e_idx] = 1'b0;
    m_lat = (m_lat | irq_req) & 32'h1FFF_FFFC;
    if (reg_we && is_en) m_en[ln*8 +: 8] = reg_wdata;
    m_en = m_en & 32'h1FFF_FFF0;
    if (accept) begin
      m_stk.push_front(m_imf);
      if (m_stk.size() > 8) void'(m_stk.pop_back());
      m_imf = 1'b0;
    end else if (irq_reti) begin
      m_imf = (m_stk.size() > 0) ? m_stk.pop_front() : 1'b0;
    end else if (reg_we && reg_addr == 8'h3A) begin
      m_imf = reg_wdata[0];
    end
    e_valid = 0; e_idx = '0;
    for (int i = 2; i <= 28; i++) begin
      if (!e_valid && m_lat[i] && (i <= 3 || (m_imf && m_en[i]))) begin
        e_valid = 1; e_idx = 5'(i);
      end
    end
  endtask

  task automatic check_outputs();
    n_vec++;
    if (req_valid !== e_valid || (e_valid && req_idx !== e_idx)) begin
      n_bad++;
      $display("FAIL %s req valid/idx act %0b/%0d exp %0b/%0d", tag, req_valid, req_idx, e_valid, e_idx);
    end
    n_vec++;
    if (reg_rdata !== e_rd) begin
      n_bad++;
      $display("FAIL %s (R10 read) rdata act %02h exp %02h", tag, reg_rdata, e_rd);
    end
  endtask

  task automatic step(input logic [31:0] rq, input bit ak, input bit rt,
                      input bit we, input logic [7:0] ad, input logic [7:0] wd);
    irq_req = rq; irq_ack = ak; irq_reti = rt;
    reg_we = we; reg_addr = ad; reg_wdata = wd;
    @(posedge clk);
    model_update();
    @(negedge clk);
    check_outputs();
  endtask

  task automatic idle(input logic [7:0] ad);
    step('0, 0, 0, 0, ad, 8'h00);
  endtask

  initial begin
    logic [31:0] lf;
    lf = 32'hACE1_2468;
    @(negedge clk);
    tag = "R1";
    step('0, 0, 0, 0, 8'h3C, 0);
    step('0, 0, 0, 0, 8'h3C, 0);
    rst = 1'b0;
    idle(8'h3A); idle(8'h3C); idle(8'h2F);

    tag = "R2";
    step(32'h0000_0401, 0, 0, 0, 8'h3D, 0);
    idle(8'h3D); idle(8'h3C);
    step(32'h1000_0000 | 32'hE000_0002, 0, 0, 0, 8'h2F, 0);
    idle(8'h2F); idle(8'h2F);

    tag = "R6";
    step(32'h0000_0008, 0, 0, 0, 8'h3C, 0);
    idle(8'h3C);
    tag = "R8";
    step('0, 1, 0, 0, 8'h3C, 0);
    idle(8'h3C);
    step('0, 1, 0, 0, 8'h3C, 0);

    tag = "R5";
    step(32'h0000_1000, 0, 0, 0, 8'h3D, 0);
    step('0, 0, 0, 1, 8'h3B, 8'h10);
    idle(8'h3B);
    step('0, 0, 0, 1, 8'h3A, 8'hFF);
    idle(8'h3A);
    tag = "R7";
    step(32'h0010_0020, 0, 0, 1, 8'h2C, 8'h10);
    step('0, 0, 0, 1, 8'h3A, 8'h21);
    idle(8'h3C);
    tag = "R8";
    step('0, 1, 0, 0, 8'h3C, 0);
    idle(8'h3A);
    tag = "R9";
    step('0, 0, 1, 0, 8'h3A, 0);
    idle(8'h3A);

    tag = "R3";
    step('0, 0, 0, 1, 8'h3D, 8'hFF);
    idle(8'h3D);
    step('0, 0, 0, 1, 8'h3D, 8'h00);
    idle(8'h3D);
    step('0, 0, 0, 1, 8'h3D, 8'hFF);
    idle(8'h3D);

    tag = "R4";
    step(32'h0010_0000, 0, 0, 1, 8'h2E, 8'h00);
    idle(8'h2E);
    step(32'h0000_0020, 0, 0, 0, 8'h3C, 0);
    step(32'h0000_0020, 1, 0, 0, 8'h3C, 0);
    idle(8'h3C);

    tag = "R9";
    for (int k = 0; k < 10; k++) begin
      step('0, 0, 0, 1, 8'h3A, (k % 3 == 0) ? 8'h01 : 8'h00);
      step(32'h0000_0004, 0, 0, 0, 8'h3A, 0);
      step('0, 1, 0, 0, 8'h3A, 0);
    end
    for (int k = 0; k < 11; k++) step('0, 0, 1, 0, 8'h3A, 0);

    tag = "R11";
    step(32'h0000_0004, 0, 0, 1, 8'h3A, 8'h01);
    step('0, 1, 1, 1, 8'h3A, 8'h01);
    idle(8'h3A);
    step('0, 0, 1, 1, 8'h3A, 8'h01);
    idle(8'h3A);

    tag = "R10";
    step('0, 0, 0, 1, 8'h2D, 8'hFF);
    step('0, 0, 0, 1, 8'h40, 8'hFF);
    idle(8'h2D); idle(8'h40); idle(8'h3A);

    tag = "R7 sweep";
    for (int k = 0; k < 600; k++) begin
      logic [31:0] a, b;
      logic [7:0] ad;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      a = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      b = lf;
      case ((a[3:0] + b[7:4]) % 9)
        0: ad = 8'h3A; 1: ad = 8'h3B; 2: ad = 8'h2C; 3: ad = 8'h2D;
        4: ad = 8'h3C; 5: ad = 8'h3D; 6: ad = 8'h2E; 7: ad = 8'h2F;
        default: ad = 8'h51;
      endcase
      step(a & b & {b[15:0], a[31:16]}, a[4], b[9] & a[9], b[2], ad, a[23:16] ^ b[31:24]);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired act running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule